// File: doc/BRIEF.md
# Transceiver Reconfiguration Sequencer

This block is a bus master that walks a transceiver channel, or the PLL or clock-recovery unit behind it, through a safe reconfiguration. It drives a memory-mapped configuration port with address, read, write, write data, read data and a wait-request stall. A single start pulse runs the whole ordered procedure. First, the channel is optionally held in reset. Next, background calibration is switched off and the switch-off is confirmed. For PLL-class targets, ownership of the internal configuration bus is handed to the calibration engine and taken back once that engine goes idle. Then a caller-supplied list of register writes is streamed. Recalibration is requested and awaited when the rate or protocol changed. Finally, background calibration is optionally switched back on.

Options are captured at start: hold the channel in reset, treat the target as a PLL or clock-recovery unit, flag a rate or protocol change, and re-enable background calibration at the end. The write list arrives on a valid/ready port that carries an address, data and a last flag. Every single-bit update is done as a read followed by a write, so that the other bits of the register are kept. Each polling phase is bounded by a programmable cycle limit. When that limit is reached, the sequence ends with an error pulse.

Top module: `xcvr_reconfig_seq`

## Requirements
- R1: After reset, busy, done, error, chan_reset, cfg_read, cfg_write and wl_ready are all low.
- R2: A start pulse while idle first reads address 0x542. It then writes the value it read back to 0x542 with bit 0 cleared and every other bit unchanged.
- R3: After that write, the block reads 0x542. If bit 0 is 0, calibration counts as off. Otherwise it reads 0x481, where bit 2 equal to 0 also counts as off. Otherwise it reads 0x542 again, and the loop continues.
- R4: With opt_pll set, the block read-modify-writes PRE_ADDR, setting bit PRE_BIT. It then writes 0x1 to address 0x000 and waits until pll_cal_busy and rx_cal_busy are both low. After that it writes 0x2 to address 0x000. With opt_pll clear, none of these transactions occur.
- R5: Each accepted list element (wl_valid and wl_ready high) produces exactly one write of its address and data, in arrival order. The element marked wl_last is the final one.
- R6: With opt_rate_chg set, after the list the block read-modify-writes RECAL_ADDR, setting bit RECAL_BIT. It then waits until tx_cal_busy, rx_cal_busy and pll_cal_busy are all low before going on.
- R7: With opt_bg_en set, the last transactions read 0x542 and write it back with bit 0 set and other bits unchanged.
- R8: chan_reset is high from the cycle after start until the sequence ends, when opt_reset or opt_rate_chg is set. Otherwise it stays low.
- R9: A transaction keeps its address, data and strobe stable while cfg_waitreq is high. Read and write are never high together.
- R10: If a polling phase is still unsatisfied after timeout_cycles cycles, the sequence ends with a one-cycle error pulse, no done pulse and no further writes.
- R11: A successful sequence ends with a one-cycle done pulse, and busy is high from start until then. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence (accepted only when idle) |
| opt_reset | input | 1 | Hold the channel in reset during the sequence |
| opt_pll | input | 1 | Target is a PLL or clock-recovery unit |
| opt_rate_chg | input | 1 | Rate or protocol changes; forces reset and recalibration |
| opt_bg_en | input | 1 | Re-enable background calibration at the end |
| timeout_cycles | input | TW | Cycle limit for each polling phase |
| wl_valid | input | 1 | Write-list element available |
| wl_ready | output | 1 | Write-list element accepted |
| wl_addr | input | AW | Write-list address |
| wl_data | input | DW | Write-list data |
| wl_last | input | 1 | Final element of the list |
| tx_cal_busy | input | 1 | Transmit calibration running |
| rx_cal_busy | input | 1 | Receive or clock-recovery calibration running |
| pll_cal_busy | input | 1 | PLL calibration running |
| cfg_addr | output | AW | Configuration bus address |
| cfg_read | output | 1 | Configuration read strobe |
| cfg_write | output | 1 | Configuration write strobe |
| cfg_wdata | output | DW | Configuration write data |
| cfg_rdata | input | DW | Configuration read data |
| cfg_waitreq | input | 1 | Configuration bus stall |
| chan_reset | output | 1 | Channel reset request |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| error | output | 1 | One-cycle pulse on poll timeout |

## Verification
A plain channel run with no options and a two-element list fixes the minimal transaction order. It shows that the PLL hand-off, recalibration and re-enable steps are skipped when they are not asked for. A full PLL run with rate change and re-enable, on a stalling bus, separates the hand-off ordering and both busy waits from the list writes. It also checks that the mask-preserving updates keep foreign bits. A run where 0x542 never clears but 0x481 bit 2 does exercises the alternate confirmation path. A run where neither clears exercises the timeout. A second start issued mid-run with different options shows whether the block latched anything from it.

// File: rtl/xcvr_reconfig_seq.sv
module xcvr_reconfig_seq #(
  parameter int AW         = 11,
  parameter int DW         = 32,
  parameter int TW         = 16,
  parameter int PRE_ADDR   = 'h0E0,
  parameter int PRE_BIT    = 0,
  parameter int RECAL_ADDR = 'h100,
  parameter int RECAL_BIT  = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          opt_reset,
  input  logic          opt_pll,
  input  logic          opt_rate_chg,
  input  logic          opt_bg_en,
  input  logic [TW-1:0] timeout_cycles,
  input  logic          wl_valid,
  output logic          wl_ready,
  input  logic [AW-1:0] wl_addr,
  input  logic [DW-1:0] wl_data,
  input  logic          wl_last,
  input  logic          tx_cal_busy,
  input  logic          rx_cal_busy,
  input  logic          pll_cal_busy,
  output logic [AW-1:0] cfg_addr,
  output logic          cfg_read,
  output logic          cfg_write,
  output logic [DW-1:0] cfg_wdata,
  input  logic [DW-1:0] cfg_rdata,
  input  logic          cfg_waitreq,
  output logic          chan_reset,
  output logic          busy,
  output logic          done,
  output logic          error
);

  localparam logic [AW-1:0] BGC_A  = AW'('h542);
  localparam logic [AW-1:0] STAT_A = AW'('h481);
  localparam logic [AW-1:0] OWN_A  = AW'(0);
  localparam logic [AW-1:0] PRE_A  = AW'(PRE_ADDR);
  localparam logic [AW-1:0] RC_A   = AW'(RECAL_ADDR);
  localparam logic [DW-1:0] BGC_M  = DW'(1);
  localparam logic [DW-1:0] PRE_M  = DW'(1) << PRE_BIT;
  localparam logic [DW-1:0] RC_M   = DW'(1) << RECAL_BIT;

  typedef enum logic [4:0] {
    S_IDLE, S_OFF_RD, S_OFF_WR, S_CHK_A, S_CHK_B, S_PRE_RD, S_PRE_WR,
    S_HAND, S_HWAIT, S_ARB, S_LIST, S_LWR, S_RC_RD, S_RC_WR, S_RWAIT,
    S_ON_RD, S_ON_WR
  } st_t;

  st_t st;
  logic [DW-1:0] rmw, ld;
  logic [AW-1:0] la;
  logic llast, pll_q, rate_q, bg_q;
  logic [TW-1:0] tcnt;

  wire ack      = ~cfg_waitreq;
  wire tmo      = tcnt >= timeout_cycles;
  wire poll     = (st == S_CHK_A) || (st == S_CHK_B) || (st == S_HWAIT) || (st == S_RWAIT);
  wire hand_idl = ~pll_cal_busy & ~rx_cal_busy;
  wire cal_idl  = hand_idl & ~tx_cal_busy;
  wire st_t off_nx = pll_q ? S_PRE_RD : S_LIST;

  assign busy     = st != S_IDLE;
  assign wl_ready = st == S_LIST;

  always_comb begin
    cfg_addr  = '0;
    cfg_read  = 1'b0;
    cfg_write = 1'b0;
    cfg_wdata = '0;
    case (st)
      S_OFF_RD, S_CHK_A, S_ON_RD: begin cfg_addr = BGC_A; cfg_read = 1'b1; end
      S_CHK_B:  begin cfg_addr = STAT_A; cfg_read = 1'b1; end
      S_OFF_WR: begin cfg_addr = BGC_A; cfg_write = 1'b1; cfg_wdata = rmw & ~BGC_M; end
      S_ON_WR:  begin cfg_addr = BGC_A; cfg_write = 1'b1; cfg_wdata = rmw | BGC_M; end
      S_PRE_RD: begin cfg_addr = PRE_A; cfg_read = 1'b1; end
      S_PRE_WR: begin cfg_addr = PRE_A; cfg_write = 1'b1; cfg_wdata = rmw | PRE_M; end
      S_HAND:   begin cfg_addr = OWN_A; cfg_write = 1'b1; cfg_wdata = DW'(1); end
      S_ARB:    begin cfg_addr = OWN_A; cfg_write = 1'b1; cfg_wdata = DW'(2); end
      S_LWR:    begin cfg_addr = la; cfg_write = 1'b1; cfg_wdata = ld; end
      S_RC_RD:  begin cfg_addr = RC_A; cfg_read = 1'b1; end
      S_RC_WR:  begin cfg_addr = RC_A; cfg_write = 1'b1; cfg_wdata = rmw | RC_M; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tcnt <= '0;
    else if (!poll) tcnt <= '0;
    else if (tcnt != '1) tcnt <= tcnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; rmw <= '0; la <= '0; ld <= '0; llast <= 1'b0;
      pll_q <= 1'b0; rate_q <= 1'b0; bg_q <= 1'b0;
      chan_reset <= 1'b0; done <= 1'b0; error <= 1'b0;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          pll_q <= opt_pll; rate_q <= opt_rate_chg; bg_q <= opt_bg_en;
          chan_reset <= opt_reset | opt_rate_chg;
          st <= S_OFF_RD;
        end
        S_OFF_RD: if (ack) begin rmw <= cfg_rdata; st <= S_OFF_WR; end
        S_OFF_WR: if (ack) st <= S_CHK_A;
        S_CHK_A: if (ack) begin
          if (!cfg_rdata[0]) st <= off_nx;
          else if (tmo) begin st <= S_IDLE; error <= 1'b1; chan_reset <= 1'b0; end
          else st <= S_CHK_B;
        end
        S_CHK_B: if (ack) begin
          if (!cfg_rdata[2]) st <= off_nx;
          else if (tmo) begin st <= S_IDLE; error <= 1'b1; chan_reset <= 1'b0; end
          else st <= S_CHK_A;
        end
        S_PRE_RD: if (ack) begin rmw <= cfg_rdata; st <= S_PRE_WR; end
        S_PRE_WR: if (ack) st <= S_HAND;
        S_HAND:   if (ack) st <= S_HWAIT;
        S_HWAIT:
          if (tcnt != '0 && hand_idl) st <= S_ARB;
          else if (tmo) begin st <= S_IDLE; error <= 1'b1; chan_reset <= 1'b0; end
        S_ARB:    if (ack) st <= S_LIST;
        S_LIST: if (wl_valid) begin
          la <= wl_addr; ld <= wl_data; llast <= wl_last; st <= S_LWR;
        end
        S_LWR: if (ack) begin
          if (!llast) st <= S_LIST;
          else if (rate_q) st <= S_RC_RD;
          else if (bg_q) st <= S_ON_RD;
          else begin st <= S_IDLE; done <= 1'b1; chan_reset <= 1'b0; end
        end
        S_RC_RD: if (ack) begin rmw <= cfg_rdata; st <= S_RC_WR; end
        S_RC_WR: if (ack) st <= S_RWAIT;
        S_RWAIT:
          if (tcnt != '0 && cal_idl) begin
            if (bg_q) st <= S_ON_RD;
            else begin st <= S_IDLE; done <= 1'b1; chan_reset <= 1'b0; end
          end else if (tmo) begin st <= S_IDLE; error <= 1'b1; chan_reset <= 1'b0; end
        S_ON_RD: if (ack) begin rmw <= cfg_rdata; st <= S_ON_WR; end
        S_ON_WR: if (ack) begin st <= S_IDLE; done <= 1'b1; chan_reset <= 1'b0; end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R9
  rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_read && cfg_write));

  // R9
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_read || cfg_write) && cfg_waitreq) |=>
      ($stable(cfg_addr) && $stable(cfg_read) && $stable(cfg_write) && $stable(cfg_wdata)));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  // R8
  reset_in_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_reset |-> busy);

  // R5
  list_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wl_valid && wl_ready) |=> (cfg_write && !cfg_read));

  // R4
  arb_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == S_ARB) |-> $past(!pll_cal_busy && !rx_cal_busy));

endmodule

// File: tb/xcvr_reconfig_seq_tb.sv
module xcvr_reconfig_seq_tb;
  localparam int AW = 11, DW = 32, TW = 16;

  logic clk = 0, rst_n = 0;
  logic start = 0, opt_reset = 0, opt_pll = 0, opt_rate_chg = 0, opt_bg_en = 0;
  logic [TW-1:0] timeout_cycles = 16'd200;
  logic wl_valid, wl_ready, wl_last;
  logic [AW-1:0] wl_addr;
  logic [DW-1:0] wl_data;
  logic tx_cal_busy, rx_cal_busy, pll_cal_busy;
  logic [AW-1:0] cfg_addr;
  logic cfg_read, cfg_write, cfg_waitreq;
  logic [DW-1:0] cfg_wdata, cfg_rdata;
  logic chan_reset, busy, done, error;

  always #4 clk = ~clk;

  xcvr_reconfig_seq u_dut (.*);

  int checks = 0, errors = 0;

  logic [DW-1:0] mem [0:2047];
  logic stuck = 0, stall_en = 0, log_clr = 0, feed_en = 0;
  logic [3:0] cyc = 0;
  int pll_cnt = 0, rc_cnt = 0, viol = 0;
  int lg_n = 0, wr_n = 0, done_cnt = 0, ready_seen = 0, rst_seen = 0;
  logic [AW-1:0] lg_a [0:63];
  logic [DW-1:0] lg_d [0:63];
  logic lg_w [0:63];
  logic [AW-1:0] fa [0:7];
  logic [DW-1:0] fd [0:7];
  int fn = 0, fi = 0;

  function automatic logic [DW-1:0] rdv(input logic [AW-1:0] a);
    return (a == 11'h542 && stuck) ? (mem[a] | 32'h1) : mem[a];
  endfunction

  assign cfg_waitreq  = stall_en && (cyc[1:0] != 2'd0);
  assign cfg_rdata    = rdv(cfg_addr);
  assign pll_cal_busy = (pll_cnt != 0) || (rc_cnt != 0);
  assign rx_cal_busy  = rc_cnt > 2;
  assign tx_cal_busy  = rc_cnt > 4;
  assign wl_valid     = feed_en && (fi < fn);
  assign wl_addr      = fa[fi[2:0]];
  assign wl_data      = fd[fi[2:0]];
  assign wl_last      = fi == fn - 1;

  always_ff @(posedge clk) begin
    cyc <= cyc + 1'b1;
    if (pll_cnt != 0) pll_cnt <= pll_cnt - 1;
    if (rc_cnt != 0) rc_cnt <= rc_cnt - 1;
    if (wl_valid && wl_ready) fi <= fi + 1;
    if (log_clr) begin
      lg_n <= 0; wr_n <= 0; done_cnt <= 0; ready_seen <= 0; rst_seen <= 0; viol <= 0; fi <= 0;
    end else begin
      if (done) done_cnt <= done_cnt + 1;
      if (wl_ready) ready_seen <= 1;
      if (chan_reset) rst_seen <= 1;
      if ((cfg_read || cfg_write) && !cfg_waitreq) begin
        if (lg_n < 64) begin
          lg_a[lg_n] <= cfg_addr;
          lg_w[lg_n] <= cfg_write;
          lg_d[lg_n] <= cfg_write ? cfg_wdata : rdv(cfg_addr);
        end
        lg_n <= lg_n + 1;
        if (cfg_write) begin
          wr_n <= wr_n + 1;
          mem[cfg_addr] <= cfg_wdata;
          if (cfg_addr == 0 && cfg_wdata == 1) pll_cnt <= 6;
          if (cfg_addr == 0 && cfg_wdata == 2 && (pll_cal_busy || rx_cal_busy)) viol <= viol + 1;
          if (cfg_addr == 11'h100 && cfg_wdata[0]) rc_cnt <= 8;
          if (cfg_addr != 0 && cfg_addr != 11'h100 && cfg_addr != 11'h542 && cfg_addr != 11'h0E0
              && (tx_cal_busy || rx_cal_busy || pll_cal_busy || pll_cnt != 0)) viol <= viol + 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic tx(input int i, input bit w, input logic [AW-1:0] a,
                    input logic [DW-1:0] d, input string req);
    bit ok = (lg_w[i] == w) && (lg_a[i] == a) && (!w || lg_d[i] == d);
    chk(ok, req, $sformatf("txn %0d (w=%0d addr/data)", i, w),
        {lg_w[i], lg_a[i], lg_d[i][15:0]}, {w, a, d[15:0]});
  endtask

  task automatic prep(input int n);
    @(negedge clk);
    log_clr = 1; feed_en = 1; fn = n;
    @(negedge clk);
    log_clr = 0;
  endtask

  task automatic run(input bit r, input bit p, input bit rc, input bit bg);
    int wd = 0;
    opt_reset = r; opt_pll = p; opt_rate_chg = rc; opt_bg_en = bg;
    start = 1;
    @(negedge clk);
    start = 0;
    chk(busy, "R11", "busy after start", busy, 1);
    while (!done && !error && wd < 3000) begin @(negedge clk); wd++; end
    if (wd >= 3000) chk(0, "R11", "watchdog", 0, 1);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !error && !chan_reset && !cfg_read && !cfg_write && !wl_ready,
        "R1", "idle outputs", {busy, done, error, chan_reset, cfg_read, cfg_write, wl_ready}, 0);
  endtask

  task automatic t_plain;
    mem[11'h542] = 32'hA5A5_A5A5;
    fa[0] = 11'h010; fd[0] = 32'h11; fa[1] = 11'h011; fd[1] = 32'h22;
    prep(2); stuck = 0; stall_en = 0;
    run(0, 0, 0, 0);
    chk(done, "R11", "done pulse", done, 1);
    @(negedge clk);
    chk(!done && !busy, "R11", "done one cycle", done, 0);
    tx(0, 0, 11'h542, 0, "R2");
    tx(1, 1, 11'h542, 32'hA5A5_A5A4, "R2");
    tx(2, 0, 11'h542, 0, "R3");
    tx(3, 1, 11'h010, 32'h11, "R5");
    tx(4, 1, 11'h011, 32'h22, "R5");
    chk(lg_n == 5, "R4", "no PLL/recal/re-enable txns", lg_n, 5);
    chk(rst_seen == 0, "R8", "no channel reset", rst_seen, 0);
  endtask

  task automatic t_pll_full;
    mem[11'h542] = 32'h0000_0F01; mem[11'h0E0] = 32'h30; mem[11'h100] = 32'h80;
    fa[0] = 11'h020; fd[0] = 32'hAAA; fa[1] = 11'h021; fd[1] = 32'hBBB;
    fa[2] = 11'h022; fd[2] = 32'hCCC;
    prep(3); stuck = 0; stall_en = 1;
    run(0, 1, 1, 1);
    chk(done && !tx_cal_busy && !rx_cal_busy && !pll_cal_busy, "R6", "cal idle at done",
        {tx_cal_busy, rx_cal_busy, pll_cal_busy}, 0);
    tx(1, 1, 11'h542, 32'h0F00, "R2");
    tx(3, 0, 11'h0E0, 0, "R4");
    tx(4, 1, 11'h0E0, 32'h31, "R4");
    tx(5, 1, 11'h000, 32'h1, "R4");
    tx(6, 1, 11'h000, 32'h2, "R4");
    tx(7, 1, 11'h020, 32'hAAA, "R5");
    tx(8, 1, 11'h021, 32'hBBB, "R5");
    tx(9, 1, 11'h022, 32'hCCC, "R5");
    tx(10, 0, 11'h100, 0, "R6");
    tx(11, 1, 11'h100, 32'h81, "R6");
    tx(12, 0, 11'h542, 0, "R7");
    tx(13, 1, 11'h542, 32'h0F01, "R7");
    chk(lg_n == 14, "R7", "txn count", lg_n, 14);
    chk(viol == 0, "R4", "ordering against busy", viol, 0);
    chk(rst_seen == 1, "R8", "reset held on rate change", rst_seen, 1);
    @(negedge clk);
    chk(!chan_reset, "R8", "reset released", chan_reset, 0);
    stall_en = 0;
  endtask

  task automatic t_alt_confirm;
    mem[11'h542] = 32'h3; mem[11'h481] = 32'hFB;
    fa[0] = 11'h030; fd[0] = 32'h5;
    prep(1); stuck = 1;
    run(1, 0, 0, 0);
    chk(done, "R3", "done via 0x481", done, 1);
    tx(1, 1, 11'h542, 32'h2, "R2");
    tx(2, 0, 11'h542, 0, "R3");
    tx(3, 0, 11'h481, 0, "R3");
    tx(4, 1, 11'h030, 32'h5, "R3");
    chk(rst_seen == 1, "R8", "reset on request", rst_seen, 1);
    stuck = 0;
  endtask

  task automatic t_timeout;
    mem[11'h542] = 32'h1; mem[11'h481] = 32'h4;
    fa[0] = 11'h040; fd[0] = 32'h9;
    prep(1); stuck = 1; timeout_cycles = 16'd20;
    run(0, 0, 0, 0);
    chk(error, "R10", "error pulse", error, 1);
    repeat (20) @(negedge clk);
    chk(done_cnt == 0, "R10", "no done", done_cnt, 0);
    chk(wr_n == 1, "R10", "only the disable write", wr_n, 1);
    chk(ready_seen == 0 && !busy, "R10", "list untouched, idle", ready_seen, 0);
    stuck = 0; timeout_cycles = 16'd200;
  endtask

  task automatic t_restart;
    int wd = 0;
    mem[11'h542] = 32'h1;
    fa[0] = 11'h050; fd[0] = 32'h7;
    prep(1); stall_en = 1; feed_en = 0;
    opt_reset = 0; opt_pll = 0; opt_rate_chg = 0; opt_bg_en = 0;
    start = 1; @(negedge clk); start = 0;
    repeat (4) @(negedge clk);
    opt_pll = 1; opt_rate_chg = 1; start = 1; @(negedge clk); start = 0;
    opt_pll = 0; opt_rate_chg = 0;
    feed_en = 1;
    while (!done && !error && wd < 3000) begin @(negedge clk); wd++; end
    repeat (40) @(negedge clk);
    chk(done_cnt == 1, "R11", "single done for ignored start", done_cnt, 1);
    chk(lg_n == 4 && rst_seen == 0, "R11", "no options taken from second start", lg_n, 4);
    stall_en = 0;
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_pll_full();
    t_alt_confirm();
    t_timeout();
    t_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL R11 global watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule